// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the synchronous command decoder and mode controller for a block-erasable flash memory model. It samples bus write cycles and runs the two-step program and erase sequences. It chooses what a read returns: array data, identifier codes or the status byte. Before starting any operation, it checks whether the target block is protected. An accepted operation produces a one-cycle start pulse. The target address and data are held on registered outputs for the array side.

The array has eleven erase blocks. Reading from the protected end of the address space, they are: one boot block of 1/64 of the array, two parameter blocks of 1/128 each, one main block that fills up to the first 1/8 boundary, and seven main blocks of 1/8 each. A parameter chooses whether the boot block sits at the lowest or the highest address. A countdown timer stands in for the array's algorithm time. While it runs, the controller reports busy.

A write cycle is any clock edge at which both `ce_n_i` and `we_n_i` are low. The command byte is `wdata_i[7:0]`. Holding `rp_n_i` low puts the controller into power-down and returns it to its reset condition.

Top module: `bbf_cmd_ctrl`

## Requirements
- R1: While `rp_n_i` is low, `dq_oe_o` is low. Each edge with `rp_n_i` low clears every status error bit, stops a running operation and drops a pending setup. It also selects array reads, so `dout_o` equals `arr_rdata_i`. The asynchronous `rst_n` gives the same state.
- R2: Command FFh selects array reads, and `dout_o` then follows `arr_rdata_i`.
- R3: Command 90h selects identifier reads. With `addr_i[0]`=0, `dout_o` is 0089h. With `addr_i[0]`=1, `dout_o` is 889Dh for a bottom-boot layout or 889Ch for a top-boot layout. When `word_mode_i` is low, the upper byte reads 00h.
- R4: Command 70h selects status reads, and `dout_o` is {8'h00, SR}. SR bit 7 is ready, bit 5 is erase error, bit 4 is program error, bit 3 is supply low and bit 1 is block locked. All other SR bits read 0.
- R5: Command 20h followed by a write of D0h starts an erase. `ers_go_o` pulses for exactly one cycle after the confirm edge, and `op_addr_o` holds the confirm address. Ready then stays low for BUSY_CYCLES cycles.
- R6: Command 10h or 40h followed by any write starts a program. `pgm_go_o` pulses for exactly one cycle, and `op_addr_o`/`op_data_o` hold that cycle's address and data. Ready then stays low for BUSY_CYCLES cycles.
- R7: An operation on the boot block starts only when `wp_i` or `hv_rst_i` is high. Otherwise no pulse is issued, and the matching error bit and the locked bit are set. `wp_i` has no effect on any other block.
- R8: If `vpp_ok_i` is low at the confirm or data cycle, nothing starts, and the matching error bit and the supply-low bit are set. If `vpp_ok_i` drops while busy, the operation aborts: ready returns on the next cycle, and the same two bits are set.
- R9: If an erase confirm carries any byte other than D0h, no erase starts and both error bits are set.
- R10: Error bits stay set across mode changes until command 50h or power-down clears them.
- R11: While busy, every command except 70h is ignored, including FFh and setup commands.
- R12: Any confirm or data cycle selects status reads. Status reads persist after the operation completes, until FFh is written.
- R13: An unrecognised byte written while idle changes neither the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rp_n_i | input | 1 | Reset/power-down, active low |
| hv_rst_i | input | 1 | Reset pin is at high voltage (boot unlock) |
| wp_i | input | 1 | Write-protect; high unlocks the boot block |
| vpp_ok_i | input | 1 | Program supply within range |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| word_mode_i | input | 1 | High: 16-bit bus; low: byte bus |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data / command byte in [7:0] |
| arr_rdata_i | input | 16 | Array read data from the array side |
| dout_o | output | 16 | Read data for the selected read mode |
| dq_oe_o | output | 1 | Data output drive enable |
| rdy_o | output | 1 | High when no operation is running |
| pgm_go_o | output | 1 | One-cycle program start |
| ers_go_o | output | 1 | One-cycle erase start |
| op_addr_o | output | ADDR_W | Target address of the last started operation |
| op_data_o | output | 16 | Program data of the last started operation |

## Verification
The start pulses, the read-mode change and every status bit are registered at the edge that samples the write. They are therefore due at the first falling edge after that edge. The bench drives each write for one full cycle from a falling edge and checks these results at the next falling edge. Ready goes low together with the start pulse and returns BUSY_CYCLES edges later. The bench checks ready low at the falling edge after edge BUSY_CYCLES−1 and high after edge BUSY_CYCLES. A supply drop aborts the operation at the edge that samples it, so ready is checked one falling edge later. `dout_o` and `dq_oe_o` are combinational from the registered mode and the pins, so they are checked within the same half cycle as the pin change.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ERS_SU = 2'd1,
        PH_PGM_SU = 2'd2,
        PH_BUSY   = 2'd3
    } ph_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_ID     = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_CLRSR   = 8'h50;
    localparam logic [7:0] CMD_ERS_SU  = 8'h20;
    localparam logic [7:0] CMD_PGM_SUA = 8'h10;
    localparam logic [7:0] CMD_PGM_SUB = 8'h40;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    localparam logic [7:0] ID_MANUF    = 8'h89;
    localparam logic [7:0] ID_DEV_HI   = 8'h88;
    localparam logic [7:0] ID_DEV_TOP  = 8'h9C;
    localparam logic [7:0] ID_DEV_BOT  = 8'h9D;

endpackage

// File: rtl/bbf_blk_map.sv
module bbf_blk_map #(
    parameter int ADDR_W   = 19,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              is_boot_o
);
    localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] BOOT_END = ONE << (ADDR_W - 6);
    localparam logic [ADDR_W-1:0] PAR_SZ   = ONE << (ADDR_W - 7);
    localparam logic [ADDR_W-1:0] P1_END   = BOOT_END + PAR_SZ;
    localparam logic [ADDR_W-1:0] P2_END   = P1_END + PAR_SZ;

    logic [ADDR_W-1:0] m;
    logic [3:0]        idx;

    generate
        if (TOP_BOOT) begin : g_top
            assign m = ~addr_i;
        end else begin : g_bot
            assign m = addr_i;
        end
    endgenerate

    always_comb begin
        if (m < BOOT_END)                 idx = 4'd0;
        else if (m < P1_END)              idx = 4'd1;
        else if (m < P2_END)              idx = 4'd2;
        else if (m[ADDR_W-1 -: 3] == 3'd0) idx = 4'd3;
        else                              idx = 4'd3 + {1'b0, m[ADDR_W-1 -: 3]};
    end

    assign is_boot_o = (idx == 4'd0);
endmodule

// File: rtl/bbf_busy_tmr.sv
module bbf_busy_tmr #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort_i)            cnt_d = '0;
        else if (start_i)       cnt_d = CW'(CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl
    import bbf_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter bit TOP_BOOT    = 1'b0,
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_n_i,
    input  logic              hv_rst_i,
    input  logic              wp_i,
    input  logic              vpp_ok_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              word_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic [15:0]       arr_rdata_i,
    output logic [15:0]       dout_o,
    output logic              dq_oe_o,
    output logic              rdy_o,
    output logic              pgm_go_o,
    output logic              ers_go_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [15:0]       op_data_o
);
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    typedef struct packed {
        ph_e               ph;
        rd_mode_e          md;
        logic              e_ers;
        logic              e_pgm;
        logic              v_low;
        logic              lock;
        logic              op_ers;
        logic              pgm_go;
        logic              ers_go;
        logic [ADDR_W-1:0] op_addr;
        logic [15:0]       op_data;
    } st_t;

    localparam st_t ST_RST = '{PH_IDLE, RD_ARRAY, 1'b0, 1'b0, 1'b0, 1'b0,
                               1'b0, 1'b0, 1'b0, '0, 16'h0000};

    st_t  d, q;
    logic wr, boot_hit, blk_ok, tmr_start, tmr_abort, tmr_busy, tmr_last;
    logic [7:0] cmd, sr;

    bbf_blk_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_map (
        .addr_i    (addr_i),
        .is_boot_o (boot_hit)
    );

    bbf_busy_tmr #(.CYC(BUSY_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .abort_i (tmr_abort),
        .busy_o  (tmr_busy),
        .last_o  (tmr_last)
    );

    assign wr     = !ce_n_i && !we_n_i;
    assign cmd    = wdata_i[7:0];
    assign blk_ok = !boot_hit || wp_i || hv_rst_i;

    always_comb begin
        d         = q;
        d.pgm_go  = 1'b0;
        d.ers_go  = 1'b0;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        if (!rp_n_i) begin
            d         = ST_RST;
            tmr_abort = 1'b1;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    if (wr) begin
                        case (cmd)
                            CMD_ARRAY:  d.md = RD_ARRAY;
                            CMD_STATUS: d.md = RD_STATUS;
                            CMD_IDENT:  d.md = RD_ID;
                            CMD_CLRSR: begin
                                d.e_ers = 1'b0;
                                d.e_pgm = 1'b0;
                                d.v_low = 1'b0;
                                d.lock  = 1'b0;
                            end
                            CMD_ERS_SU:               d.ph = PH_ERS_SU;
                            CMD_PGM_SUA, CMD_PGM_SUB: d.ph = PH_PGM_SU;
                            default: ;
                        endcase
                    end
                end
                PH_ERS_SU: begin
                    if (wr) begin
                        d.md = RD_STATUS;
                        d.ph = PH_IDLE;
                        if (cmd != CMD_CONFIRM) begin
                            d.e_ers = 1'b1;
                            d.e_pgm = 1'b1;
                        end else if (!blk_ok) begin
                            d.e_ers = 1'b1;
                            d.lock  = 1'b1;
                        end else if (!vpp_ok_i) begin
                            d.e_ers = 1'b1;
                            d.v_low = 1'b1;
                        end else begin
                            d.ph      = PH_BUSY;
                            d.op_ers  = 1'b1;
                            d.ers_go  = 1'b1;
                            d.op_addr = addr_i;
                            tmr_start = 1'b1;
                        end
                    end
                end
                PH_PGM_SU: begin
                    if (wr) begin
                        d.md = RD_STATUS;
                        d.ph = PH_IDLE;
                        if (!blk_ok) begin
                            d.e_pgm = 1'b1;
                            d.lock  = 1'b1;
                        end else if (!vpp_ok_i) begin
                            d.e_pgm = 1'b1;
                            d.v_low = 1'b1;
                        end else begin
                            d.ph      = PH_BUSY;
                            d.op_ers  = 1'b0;
                            d.pgm_go  = 1'b1;
                            d.op_addr = addr_i;
                            d.op_data = wdata_i;
                            tmr_start = 1'b1;
                        end
                    end
                end
                default: begin
                    if (wr && cmd == CMD_STATUS) d.md = RD_STATUS;
                    if (!vpp_ok_i) begin
                        tmr_abort = 1'b1;
                        d.ph      = PH_IDLE;
                        d.v_low   = 1'b1;
                        if (q.op_ers) d.e_ers = 1'b1;
                        else          d.e_pgm = 1'b1;
                    end else if (tmr_last) begin
                        d.ph = PH_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign sr = {!tmr_busy, 1'b0, q.e_ers, q.e_pgm, q.v_low, 1'b0, q.lock, 1'b0};

    always_comb begin
        case (q.md)
            RD_STATUS: dout_o = {8'h00, sr};
            RD_ID: begin
                if (!addr_i[0])       dout_o = {8'h00, ID_MANUF};
                else if (word_mode_i) dout_o = {ID_DEV_HI, DEV_CODE};
                else                  dout_o = {8'h00, DEV_CODE};
            end
            default:   dout_o = arr_rdata_i;
        endcase
    end

    assign dq_oe_o   = rp_n_i && !ce_n_i && !oe_n_i && we_n_i;
    assign rdy_o     = !tmr_busy;
    assign pgm_go_o  = q.pgm_go;
    assign ers_go_o  = q.ers_go;
    assign op_addr_o = q.op_addr;
    assign op_data_o = q.op_data;
endmodule

// File: rtl/bbf_cmd_ctrl_chk.sv
module bbf_cmd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rp_n,
    input logic vpp_ok,
    input logic rdy,
    input logic pgm_go,
    input logic ers_go
);
    p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_go && ers_go));

    p_go_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go || ers_go) |=> !(pgm_go || ers_go));

    p_go_marks_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go || ers_go) |-> !rdy);

    p_start_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go || ers_go) |-> $past(vpp_ok));

    p_busy_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> !(pgm_go || ers_go));

    p_powerdown_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> (rdy && !pgm_go && !ers_go));
endmodule

bind bbf_cmd_ctrl bbf_cmd_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rp_n   (rp_n_i),
    .vpp_ok (vpp_ok_i),
    .rdy    (rdy_o),
    .pgm_go (pgm_go_o),
    .ers_go (ers_go_o)
);

// File: tb/bbf_cmd_ctrl_tb.sv
module bbf_cmd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 19;
    localparam int NB         = 8;
    localparam logic [15:0] ARR = 16'hA5C3;

    logic clk = 1'b0;
    logic rst_n, rp_n, hv, wp, vpp, ce_n, we_n, oe_n, wm;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;

    logic [15:0] dout_b, dout_t, odat_b, odat_t;
    logic [AW-1:0] oadr_b, oadr_t;
    logic oe_b, oe_t, rdy_b, rdy_t, pg_b, pg_t, eg_b, eg_t;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbf_cmd_ctrl #(.ADDR_W(AW), .TOP_BOOT(1'b0), .BUSY_CYCLES(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .rp_n_i(rp_n), .hv_rst_i(hv), .wp_i(wp),
        .vpp_ok_i(vpp), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .word_mode_i(wm), .addr_i(addr), .wdata_i(wdata), .arr_rdata_i(ARR),
        .dout_o(dout_b), .dq_oe_o(oe_b), .rdy_o(rdy_b), .pgm_go_o(pg_b),
        .ers_go_o(eg_b), .op_addr_o(oadr_b), .op_data_o(odat_b));

    bbf_cmd_ctrl #(.ADDR_W(AW), .TOP_BOOT(1'b1), .BUSY_CYCLES(NB)) dut_top_i (
        .clk(clk), .rst_n(rst_n), .rp_n_i(rp_n), .hv_rst_i(hv), .wp_i(wp),
        .vpp_ok_i(vpp), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .word_mode_i(wm), .addr_i(addr), .wdata_i(wdata), .arr_rdata_i(ARR),
        .dout_o(dout_t), .dq_oe_o(oe_t), .rdy_o(rdy_t), .pgm_go_o(pg_t),
        .ers_go_o(eg_t), .op_addr_o(oadr_t), .op_data_o(odat_t));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] st(input logic r, e, p, v, l);
        return {8'h00, r, 1'b0, e, p, v, 1'b0, l, 1'b0};
    endfunction

    function automatic logic [AW-1:0] blk_start(input int i);
        if (i == 0) return '0;
        if (i <= 3) return AW'(32'h1000 * (i + 1));
        return AW'((i - 3) << 16);
    endfunction

    function automatic logic [AW-1:0] blk_end(input int i);
        if (i == 10) return '1;
        return blk_start(i + 1) - 1'b1;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] dv);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = dv;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic run_out(input string req);
        idle(NB - 1);
        chk(req, {rdy_b, rdy_t}, 2'b00);
        idle(1);
        chk(req, {rdy_b, rdy_t}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rp_n = 1'b1; hv = 1'b0; wp = 1'b0; vpp = 1'b1;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; wm = 1'b1; addr = '0; wdata = '0;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state: array read, ready
        chk("R1", {dout_b, dout_t}, {ARR, ARR});
        chk("R1", {rdy_b, rdy_t}, 2'b11);
        // R4 status read after reset
        wr('0, 16'h0070);
        chk("R4", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});

        // R3 identifier codes
        wr('0, 16'h0090);
        chk("R3", {dout_b, dout_t}, {16'h0089, 16'h0089});
        addr = AW'(1); #1;
        chk("R3", {dout_b, dout_t}, {16'h889D, 16'h889C});
        wm = 1'b0; #1;
        chk("R3", {dout_b, dout_t}, {16'h009D, 16'h009C});
        wm = 1'b1;

        // R13 unknown command ignored
        wr('0, 16'h0033);
        chk("R13", {dout_b, dout_t}, {16'h0089, 16'h0089});
        // R2 read array
        wr('0, 16'h00FF);
        chk("R2", {dout_b, dout_t}, {ARR, ARR});
        wr('0, 16'h0070);
        wr('0, 16'h00A7);
        chk("R13", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});

        // R6 program with 40h, R11 commands ignored while busy, R12
        wr('0, 16'h0040);
        wr(AW'(32'h40000), 16'h1234);
        chk("R6", {pg_b, pg_t, eg_b, eg_t}, 4'b1100);
        chk("R6", {oadr_b, oadr_t}, {AW'(32'h40000), AW'(32'h40000)});
        chk("R6", {odat_b, odat_t}, {16'h1234, 16'h1234});
        chk("R12", {dout_b, dout_t}, {st(0,0,0,0,0), st(0,0,0,0,0)});
        wr('0, 16'h00FF);
        chk("R6", {pg_b, pg_t}, 2'b00);
        chk("R11", {dout_b, dout_t}, {st(0,0,0,0,0), st(0,0,0,0,0)});
        wr('0, 16'h0020);
        idle(NB - 3);
        chk("R6", {rdy_b, rdy_t}, 2'b00);
        idle(1);
        chk("R6", {rdy_b, rdy_t}, 2'b11);
        chk("R12", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});
        wr(AW'(32'h12345), 16'h00D0);
        chk("R11", {eg_b, eg_t}, 2'b00);
        wr('0, 16'h00FF);
        chk("R12", {dout_b, dout_t}, {ARR, ARR});

        // R6 program with 10h
        wr('0, 16'h0010);
        wr(AW'(32'h20001), 16'hBEEF);
        chk("R6", {pg_b, pg_t}, 2'b11);
        chk("R6", {odat_b, odat_t}, {16'hBEEF, 16'hBEEF});
        run_out("R6");

        // R5 erase
        wr('0, 16'h0020);
        wr(AW'(32'h12345), 16'h00D0);
        chk("R5", {eg_b, eg_t, pg_b, pg_t}, 4'b1100);
        chk("R5", {oadr_b, oadr_t}, {AW'(32'h12345), AW'(32'h12345)});
        idle(1);
        chk("R5", {eg_b, eg_t}, 2'b00);
        idle(NB - 2);
        chk("R5", {rdy_b, rdy_t}, 2'b00);
        idle(1);
        chk("R5", {rdy_b, rdy_t}, 2'b11);

        // R7 sweep over the first and last word of every block, both layouts
        for (int i = 0; i < 11; i++) begin
            for (int e = 0; e < 2; e++) begin
                logic [AW-1:0] a;
                logic bb, bt;
                a  = (e == 0) ? blk_start(i) : blk_end(i);
                bb = (a < AW'(32'h2000));
                bt = (a >= AW'(32'h7E000));
                wr('0, 16'h0040);
                wr(a, 16'h5A5A);
                chk("R7", {pg_b, pg_t}, {!bb, !bt});
                chk("R7", dout_b, bb ? st(1,0,1,0,1) : st(0,0,0,0,0));
                chk("R7", dout_t, bt ? st(1,0,1,0,1) : st(0,0,0,0,0));
                idle(NB);
                wr('0, 16'h0050);
                chk("R10", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});
            end
        end

        // R7 unlock by write-protect high (bottom) and high-voltage reset (top)
        wp = 1'b1;
        wr('0, 16'h0040);
        wr('0, 16'h0101);
        chk("R7", pg_b, 1'b1);
        idle(NB);
        wp = 1'b0; hv = 1'b1;
        wr('0, 16'h0040);
        wr('1, 16'h0202);
        chk("R7", {pg_b, pg_t}, 2'b11);
        idle(NB);
        hv = 1'b0;
        // R7 locked erase
        wr('0, 16'h0020);
        wr(AW'(32'h100), 16'h00D0);
        chk("R7", {eg_b, eg_t}, 2'b01);
        chk("R7", dout_b, st(1,1,0,0,1));
        idle(NB);
        wr('0, 16'h0050);

        // R8 supply low at data cycle
        vpp = 1'b0;
        wr('0, 16'h0040);
        wr(AW'(32'h50000), 16'h7777);
        chk("R8", {pg_b, pg_t}, 2'b00);
        chk("R8", {dout_b, dout_t}, {st(1,0,1,1,0), st(1,0,1,1,0)});
        vpp = 1'b1;
        wr('0, 16'h0050);
        // R8 supply drop during erase
        wr('0, 16'h0020);
        wr(AW'(32'h50000), 16'h00D0);
        chk("R8", {rdy_b, rdy_t}, 2'b00);
        vpp = 1'b0;
        idle(1);
        vpp = 1'b1;
        chk("R8", {rdy_b, rdy_t}, 2'b11);
        chk("R8", {dout_b, dout_t}, {st(1,1,0,1,0), st(1,1,0,1,0)});

        // R10 error bits survive mode changes
        wr('0, 16'h00FF);
        wr('0, 16'h0070);
        chk("R10", {dout_b, dout_t}, {st(1,1,0,1,0), st(1,1,0,1,0)});
        wr('0, 16'h0050);
        chk("R10", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});

        // R9 bad confirm byte
        wr('0, 16'h00FF);
        wr('0, 16'h0020);
        wr(AW'(32'h60000), 16'h0077);
        chk("R9", {eg_b, eg_t}, 2'b00);
        chk("R9", {dout_b, dout_t}, {st(1,1,1,0,0), st(1,1,1,0,0)});

        // R1 power-down: output disable, status clear, pending setup dropped
        ce_n = 1'b0; oe_n = 1'b0; #1;
        chk("R1", {oe_b, oe_t}, 2'b11);
        rp_n = 1'b0; #1;
        chk("R1", {oe_b, oe_t}, 2'b00);
        idle(1);
        ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1;
        chk("R1", {dout_b, dout_t}, {ARR, ARR});
        wr('0, 16'h0070);
        chk("R1", {dout_b, dout_t}, {st(1,0,0,0,0), st(1,0,0,0,0)});
        wr('0, 16'h0040);
        rp_n = 1'b0;
        idle(1);
        rp_n = 1'b1;
        wr(AW'(32'h40000), 16'h1234);
        chk("R1", {pg_b, pg_t}, 2'b00);
        chk("R1", {dout_b, dout_t}, {ARR, ARR});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule